// File: doc/BRIEF.md
# Host Bus Register Interface

This block is a slave port that gives a host processor read and write access to an on-chip register file over a parallel, memory-style bus. Chip select, write enable and output enable are all active low. The host places a 10-bit byte address on the bus and holds chip select low for the whole access. The block raises a wait indication until the access can complete. On the cycle in which wait is released, write data is stored or read data becomes available.

A mode strap chooses between two ways of sampling the strobes. In synchronous mode the host bus clock drives `clk_i`, and the strobes are sampled directly. In asynchronous mode the strobes pass through a two-flop synchronizer into the system clock domain. A second strap sets the data width to 8, 16 or 32 bits, which decides how the low address bits are used. A third strap sets the active level of the wait output. Two pending-event inputs are brought out as active-low, open-drain style interrupt and wake outputs.

The register file holds 256 words of 32 bits. All of them reset to zero.

Top module: `hostbus_regif`

## Requirements
- R1: While `rst_ni` is low, the outputs are released and the access in flight is dropped. Released means `wait_o` at its inactive level, `rdata_o` zero, and `irq_no` and `wake_no` high. After reset every register word reads zero.
- R2: With `sync_mode_i` high, the address is captured at the first rising clock edge at which `cs_ni` is low. Wait is active from that edge onward.
- R3: With `sync_mode_i` low, the strobes go through two synchronizing flops. The address is captured at the third rising edge after `cs_ni` falls.
- R4: Wait stays active for exactly `WAIT_CYCLES` clock cycles (default 3) after capture. A write is committed, or read data becomes valid, on the edge that ends wait. Wait then stays inactive until chip select is released.
- R5: When `wait_pol_i` is 1, wait is active high. When `wait_pol_i` is 0, wait is active low.
- R6: Width code 2'b10 selects 32-bit mode. Address bits [1:0] are ignored, and the whole word is read or written.
- R7: Width code 2'b01 selects 16-bit mode. Address bit [0] is ignored. Address bit [1] selects the half-word: 1 selects bits [31:16], 0 selects bits [15:0]. Data travels on bits [15:0], and a write leaves the other half unchanged.
- R8: Width code 2'b00 selects 8-bit mode. Address bits [1:0] select byte lane n, which is bits [8n+7:8n]. Data travels on bits [7:0], and a write leaves the other lanes unchanged.
- R9: `rdata_o` is zero unless `cs_ni` is low, `oe_ni` is low and `we_ni` is high.
- R10: If chip select is released before wait ends, the access is abandoned and no register changes.
- R11: `irq_no` is low while `irq_pending_i` is high, and `wake_no` is low while `wake_pending_i` is high. Otherwise each output is high (released).
- R12: Address bits [9:2] select one of the 256 register words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the bus clock in synchronous mode |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| sync_mode_i | input | 1 | 1: synchronous strobe sampling; 0: synchronized (asynchronous) |
| bus_width_i | input | 2 | Width strap: 00 8-bit, 01 16-bit, 10 or 11 32-bit |
| wait_pol_i | input | 1 | Active level of `wait_o` |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not driven |
| wait_o | output | 1 | Wait indication, polarity set by `wait_pol_i` |
| irq_pending_i | input | 1 | Interrupt event pending |
| wake_pending_i | input | 1 | Wake event pending |
| irq_no | output | 1 | Interrupt, open-drain style, active low |
| wake_no | output | 1 | Wake event, open-drain style, active low |

## Verification
On every cycle the checker enforces several properties. It confirms that outputs are released during reset and that read data is gated to zero outside a read strobe. It tracks the open-drain event outputs, and it bounds the length of any wait period. It also ties the onset of wait to chip select one edge earlier in synchronous mode, or three edges earlier in asynchronous mode.

The bench scenarios cover what a property cannot see. These include the byte-lane merge in the narrow widths and the ignored address bits, as well as which half or byte comes back on a read. The scenarios also show that an abandoned or reset-interrupted access leaves the register contents untouched or cleared, and that the polarity strap flips the wait level.

// File: rtl/hbr_pkg.sv
`timescale 1ns/1ps
package hbr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    BW_8   = 2'b00,
    BW_16  = 2'b01,
    BW_32  = 2'b10,
    BW_32B = 2'b11
  } bus_width_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DONE
  } bus_state_e;

  function automatic logic [LANES-1:0] lane_mask(bus_width_e w, logic [1:0] a);
    case (w)
      BW_8:    lane_mask = LANES'(1) << a;
      BW_16:   lane_mask = a[1] ? LANES'(4'b1100) : LANES'(4'b0011);
      default: lane_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/hbr_strobe_sync.sv
`timescale 1ns/1ps
module hbr_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_mode_i,
  input  logic cs_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic cs_o,
  output logic we_o,
  output logic oe_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw_act;
  logic [NSIG-1:0] chain [STAGES];

  assign raw_act = {~oe_ni, ~we_ni, ~cs_ni};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= '0;
      else if (s == 0) chain[s] <= raw_act;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  // synchronous mode samples the pins directly at the consuming edge
  always_comb begin
    if (sync_mode_i) {oe_o, we_o, cs_o} = raw_act;
    else             {oe_o, we_o, cs_o} = chain[STAGES-1];
  end
endmodule

// File: rtl/hbr_bus_fsm.sv
`timescale 1ns/1ps
module hbr_bus_fsm
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned WAIT_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  bus_width_e        width_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output bus_width_e        width_q_o
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);

  bus_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign start_o  = (state_q == ST_IDLE) && cs_act_i;
  assign busy_o   = (state_q == ST_WAIT);
  assign commit_o = busy_o && cs_act_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      addr_q_o  <= '0;
      width_q_o <= BW_32;
    end else begin
      case (state_q)
        ST_IDLE: if (cs_act_i) begin
          state_q   <= ST_WAIT;
          cnt_q     <= CNT_W'(WAIT_CYCLES);
          addr_q_o  <= addr_i;
          width_q_o <= width_i;
        end
        ST_WAIT: begin
          if (!cs_act_i)                state_q <= ST_IDLE;
          else if (cnt_q == CNT_W'(1))  state_q <= ST_DONE;
          else                          cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: if (!cs_act_i) state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hbr_regfile.sv
`timescale 1ns/1ps
module hbr_regfile
  import hbr_pkg::*;
#(
  parameter int unsigned       NUM_WORDS  = 256,
  parameter logic [WORD_W-1:0] RESET_WORD = '0,
  localparam int unsigned      IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rword_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) mem_q[w] <= RESET_WORD;
    end else if (we_i) begin
      for (int l = 0; l < LANES; l++)
        if (lane_en_i[l]) mem_q[idx_i][8*l +: 8] <= wdata_i[8*l +: 8];
    end
  end

  assign rword_o = mem_q[idx_i];
endmodule

// File: rtl/hostbus_regif.sv
`timescale 1ns/1ps
module hostbus_regif
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned WAIT_CYCLES = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic [1:0]        bus_width_i,
  input  logic              wait_pol_i,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              wait_o,
  input  logic              irq_pending_i,
  input  logic              wake_pending_i,
  output logic              irq_no,
  output logic              wake_no
);
  localparam int unsigned NUM_WORDS = 2 ** (ADDR_W - 2);
  localparam int unsigned IDX_W     = ADDR_W - 2;

  logic              cs_act, we_act, oe_act;
  logic              start, busy, commit;
  logic [ADDR_W-1:0] addr_q;
  bus_width_e        width_q;
  logic [WORD_W-1:0] wword, rword, sh8, sh16, rd_ext, rdata_q;
  logic [LANES-1:0]  lane_en;
  logic              drive_en;

  hbr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sync_mode_i, .cs_ni, .we_ni, .oe_ni,
    .cs_o(cs_act), .we_o(we_act), .oe_o(oe_act)
  );

  hbr_bus_fsm #(.ADDR_W(ADDR_W), .WAIT_CYCLES(WAIT_CYCLES)) u_fsm (
    .clk_i, .rst_ni,
    .cs_act_i (cs_act),
    .addr_i,
    .width_i  (bus_width_e'(bus_width_i)),
    .start_o  (start),
    .busy_o   (busy),
    .commit_o (commit),
    .addr_q_o (addr_q),
    .width_q_o(width_q)
  );

  // narrow write data is replicated across lanes; lane enables pick the target
  always_comb begin
    case (width_q)
      BW_8:    wword = {LANES{wdata_i[7:0]}};
      BW_16:   wword = {(LANES/2){wdata_i[15:0]}};
      default: wword = wdata_i;
    endcase
  end

  assign lane_en = lane_mask(width_q, addr_q[1:0]);

  hbr_regfile #(.NUM_WORDS(NUM_WORDS)) u_rf (
    .clk_i, .rst_ni,
    .we_i     (commit && we_act),
    .idx_i    (addr_q[ADDR_W-1:2]),
    .lane_en_i(lane_en),
    .wdata_i  (wword),
    .rword_o  (rword)
  );

  assign sh8  = rword >> {addr_q[1:0], 3'b000};
  assign sh16 = rword >> {addr_q[1], 4'b0000};

  always_comb begin
    case (width_q)
      BW_8:    rd_ext = {24'b0, sh8[7:0]};
      BW_16:   rd_ext = {16'b0, sh16[15:0]};
      default: rd_ext = rword;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_q <= '0;
    else if (start)              rdata_q <= '0;
    else if (commit && !we_act)  rdata_q <= rd_ext;
  end

  assign drive_en = rst_ni && !cs_ni && !oe_ni && we_ni;
  assign rdata_o  = drive_en ? rdata_q : '0;
  assign wait_o   = wait_pol_i ? busy : ~busy;
  // open-drain: 0 pulls the line, 1 releases it
  assign irq_no   = ~(rst_ni && irq_pending_i);
  assign wake_no  = ~(rst_ni && wake_pending_i);

  logic unused_oe;
  assign unused_oe = oe_act;
endmodule

// File: rtl/hbr_checker.sv
`timescale 1ns/1ps
module hbr_checker #(
  parameter int unsigned WAIT_CYCLES = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sync_mode_i,
  input logic        wait_pol_i,
  input logic        cs_ni,
  input logic        we_ni,
  input logic        oe_ni,
  input logic [31:0] rdata_o,
  input logic        wait_o,
  input logic        irq_pending_i,
  input logic        wake_pending_i,
  input logic        irq_no,
  input logic        wake_no
);
  localparam int unsigned CW = $clog2(WAIT_CYCLES + 2) + 1;

  logic          busy;
  logic [CW-1:0] run_q;

  assign busy = (wait_o == wait_pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (busy) run_q <= run_q + CW'(1);
    else           run_q <= '0;
  end

  // R1
  reset_release_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (rdata_o == '0 && irq_no && wake_no && wait_o == !wait_pol_i));

  // R4
  wait_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(WAIT_CYCLES));

  // R9
  rdata_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || oe_ni || !we_ni) |-> rdata_o == '0);

  // R2
  sync_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && $rose(busy)) |-> !$past(cs_ni));

  // R3
  async_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && $rose(busy)) |-> (!$past(cs_ni, 3) && !$past(cs_ni, 2)));

  // R11
  irq_od_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !irq_pending_i);

  // R11
  wake_od_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_no == !wake_pending_i);
endmodule

bind hostbus_regif hbr_checker #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_mode_i(sync_mode_i),
  .wait_pol_i(wait_pol_i), .cs_ni(cs_ni), .we_ni(we_ni), .oe_ni(oe_ni),
  .rdata_o(rdata_o), .wait_o(wait_o), .irq_pending_i(irq_pending_i),
  .wake_pending_i(wake_pending_i), .irq_no(irq_no), .wake_no(wake_no)
);

// File: tb/hostbus_regif_test.sv
`timescale 1ns/1ps
module hostbus_regif_test;
  localparam int unsigned WAITN = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_mode_i = 1'b1;
  logic [1:0]  bus_width_i = 2'b10;
  logic        wait_pol_i = 1'b1;
  logic        cs_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wait_o;
  logic        irq_pending_i = 1'b0, wake_pending_i = 1'b0;
  logic        irq_no, wake_no;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  hostbus_regif #(.WAIT_CYCLES(WAITN)) uut (.*);

  typedef struct packed {
    logic [1:0]  w;
    logic [9:0]  a;
    logic        wr;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'b10, 10'h004, 1'b1, 32'hA1B2C3D4, 32'h0},
    '{2'b10, 10'h007, 1'b0, 32'h0,        32'hA1B2C3D4},
    '{2'b00, 10'h005, 1'b1, 32'h000000EE, 32'h0},
    '{2'b10, 10'h004, 1'b0, 32'h0,        32'hA1B2EED4},
    '{2'b00, 10'h006, 1'b0, 32'h0,        32'h000000B2},
    '{2'b01, 10'h007, 1'b1, 32'h00001234, 32'h0},
    '{2'b01, 10'h006, 1'b0, 32'h0,        32'h00001234},
    '{2'b01, 10'h005, 1'b0, 32'h0,        32'h0000EED4},
    '{2'b10, 10'h004, 1'b0, 32'h0,        32'h1234EED4},
    '{2'b10, 10'h3FC, 1'b1, 32'hDEADBEEF, 32'h0},
    '{2'b00, 10'h3FF, 1'b0, 32'h0,        32'h000000DE},
    '{2'b10, 10'h008, 1'b0, 32'h0,        32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic busy();
    return wait_o == wait_pol_i;
  endfunction

  task automatic access(input logic [1:0] w, input logic [9:0] a, input logic wr,
                        input logic [31:0] d, input logic [31:0] e,
                        input string req, input int lat_exp);
    int lat, n;
    @(negedge clk_i);
    bus_width_i = w; addr_i = a; wdata_i = d;
    cs_ni = 1'b0; we_ni = !wr; oe_ni = wr;
    lat = 0;
    while (!busy() && lat < 20) begin @(negedge clk_i); lat++; end
    chk(sync_mode_i ? "R2 capture latency" : "R3 capture latency", lat, lat_exp);
    n = 0;
    while (busy() && n < 20) begin @(negedge clk_i); n++; end
    chk("R4 wait length", n, WAITN);
    chk(req, rdata_o, e);
    cs_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    irq_pending_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1 reset state, pending event masked during reset
    chk("R1 wait idle in reset", wait_o, 1'b0);
    chk("R1 rdata in reset", rdata_o, 32'h0);
    chk("R1 irq released in reset", irq_no, 1'b1);
    rst_ni = 1'b1;
    irq_pending_i = 1'b0;
    @(negedge clk_i);

    for (int i = 0; i < 12; i++) begin
      tag = (VEC[i].w == 2'b00) ? "R8 byte lane" :
            (VEC[i].w == 2'b01) ? "R7 half word" : "R6 full word";
      if (VEC[i].wr) tag = "R9 rdata during write";
      if (i == 9 || i == 10) tag = VEC[i].wr ? "R12 high address write" : "R12 high address byte";
      access(VEC[i].w, VEC[i].a, VEC[i].wr, VEC[i].d, VEC[i].e, tag, 1);
    end

    // R9 output enable high: data bus reads zero even after a read completes
    @(negedge clk_i);
    bus_width_i = 2'b10; addr_i = 10'h004; cs_ni = 1'b0; we_ni = 1'b1; oe_ni = 1'b1;
    repeat (WAITN + 2) @(negedge clk_i);
    chk("R9 oe high gates data", rdata_o, 32'h0);
    oe_ni = 1'b0;
    #0.1;
    chk("R9 oe low drives data", rdata_o, 32'h1234EED4);
    cs_ni = 1'b1; oe_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R11 event outputs
    irq_pending_i = 1'b1;
    #0.5;
    chk("R11 irq pulled low", irq_no, 1'b0);
    chk("R11 wake released", wake_no, 1'b1);
    irq_pending_i = 1'b0; wake_pending_i = 1'b1;
    #0.5;
    chk("R11 wake pulled low", wake_no, 1'b0);
    chk("R11 irq released", irq_no, 1'b1);
    wake_pending_i = 1'b0;

    // R5 inverted wait polarity
    wait_pol_i = 1'b0;
    @(negedge clk_i);
    chk("R5 idle level low polarity", wait_o, 1'b1);
    access(2'b10, 10'h010, 1'b1, 32'h0BADF00D, 32'h0, "R5 write with low polarity", 1);
    access(2'b10, 10'h010, 1'b0, 32'h0, 32'h0BADF00D, "R5 read with low polarity", 1);
    wait_pol_i = 1'b1;

    // R3 asynchronous mode
    sync_mode_i = 1'b0;
    repeat (2) @(negedge clk_i);
    access(2'b00, 10'h011, 1'b1, 32'h00000077, 32'h0, "R3 async write", 3);
    access(2'b10, 10'h010, 1'b0, 32'h0, 32'h0BAD770D, "R3 async read", 3);
    sync_mode_i = 1'b1;
    repeat (2) @(negedge clk_i);

    // R10 abandoned write leaves register unchanged
    @(negedge clk_i);
    bus_width_i = 2'b10; addr_i = 10'h020; wdata_i = 32'hFFFFFFFF;
    cs_ni = 1'b0; we_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 wait active", busy(), 1'b1);
    cs_ni = 1'b1; we_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 wait dropped on release", busy(), 1'b0);
    repeat (3) @(negedge clk_i);
    access(2'b10, 10'h020, 1'b0, 32'h0, 32'h0, "R10 register unchanged", 1);

    // R1 reset during an access
    @(negedge clk_i);
    bus_width_i = 2'b10; addr_i = 10'h00C; wdata_i = 32'h55555555;
    cs_ni = 1'b0; we_ni = 1'b0; irq_pending_i = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    chk("R1 wait released by reset", wait_o, 1'b0);
    chk("R1 irq released by reset", irq_no, 1'b1);
    cs_ni = 1'b1; we_ni = 1'b1; irq_pending_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    access(2'b10, 10'h004, 1'b0, 32'h0, 32'h0, "R1 register back to default", 1);
    access(2'b10, 10'h00C, 1'b0, 32'h0, 32'h0, "R1 interrupted write not stored", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule